// File: doc/BRIEF.md
# Keyed Configuration Port

This block is a two-address configuration port with an index register and a data register. It holds a set of per-device configuration registers behind a lock. After reset the port is locked. Software opens it by writing the entry key byte 0x87 to the index port on two index writes in a row. Once the port is open, a write to the index port picks a configuration register, and accesses to the data port read or write that register. Writing the exit key byte 0xAA to the index port locks the port again.

A device-select register chooses which device's bank is seen through the banked registers at 0xF0 and above. Each device has its own activation bit. The block also has a read-only identification register. The bank of the watchdog device holds three registers: control, timeout and status. These three registers, together with that device's activation bit, drive output ports toward the watchdog logic.

Host reads are registered. A read strobe loads `rdData` on the clock edge where the strobe is sampled. `rdData` then holds that value until the next read strobe.

Top module: `cfgport_top`

## Requirements
- R1: After reset the port is locked, the device select and all activation bits are 0, the watchdog outputs are 0x00/0, and `rdData` is 0x00.
- R2: The port opens only after two index-port writes (`addrSel`=0) of 0x87 with no other index-port write between them. Before that, every data-port read returns 0xFF. Data-port accesses do not disturb the detection.
- R3: An index-port write of any value other than 0x87, made after a single 0x87, leaves the port locked and restarts the detection.
- R4: While the port is locked, data-port writes change no register and index-port writes other than the key bytes do not change the selected register index.
- R5: An index-port write of 0xAA while the port is open locks it. The selected index is kept for the next opening.
- R6: A read strobe loads `rdData` on its sampling edge. With `addrSel`=0 it loads the current index (0xFF when locked); otherwise it loads the addressed register value. Without a read strobe `rdData` holds its value.
- R7: Register 0x20 reads the CHIP_ID parameter (default 0x5C). Writes to it are ignored.
- R8: Register 0x07 is the 8-bit device select and reads back the value written.
- R9: Bit 0 of register 0x30 is the activation bit of the selected device, and bits 7:1 read 0. When the device select is NUM_LD or above, the register reads 0x00 and writes are ignored. `wdtActive` shows the bit of device WDT_LDN (default 8).
- R10: With device WDT_LDN selected, registers 0xF5, 0xF6 and 0xF7 are read/write and drive `wdtCtrl`, `wdtTimeout` and `wdtCsr`.
- R11: With any other device selected, registers 0xF5 to 0xF7 read 0x00 and writes to them leave the watchdog outputs unchanged.
- R12: Every register index that is not implemented reads 0x00 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addrSel | input | 1 | 0 selects the index port, 1 selects the data port |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Registered read data |
| wdtCtrl | output | 8 | Watchdog control register |
| wdtTimeout | output | 8 | Watchdog timeout register |
| wdtCsr | output | 8 | Watchdog control/status register |
| wdtActive | output | 1 | Activation bit of the watchdog device |

## Verification
The bench builds the block with its default parameters: NUM_LD=12, WDT_LDN=8 and CHIP_ID=0x5C. Because NUM_LD is 12, device-select values from 12 to 255 exist and can be written. This makes the out-of-range activation path reachable: such writes are ignored and the register reads 0x00. Device numbers both below and above the watchdog device can also be selected to check the banking. Because CHIP_ID is not 0xFF, the identification read is easy to tell apart from a locked read.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;
  localparam int DW = 8;
  localparam int WDT_REGS = 3;

  localparam logic [DW-1:0] ENTER_KEY    = 8'h87;
  localparam logic [DW-1:0] EXIT_KEY     = 8'hAA;
  localparam logic [DW-1:0] REG_DEVSEL   = 8'h07;
  localparam logic [DW-1:0] REG_IDENT    = 8'h20;
  localparam logic [DW-1:0] REG_ACTIVE   = 8'h30;
  localparam logic [DW-1:0] REG_WDT_BASE = 8'hF5;
  localparam logic [DW-1:0] LOCKED_READ  = 8'hFF;

  typedef enum logic [1:0] {
    ST_LOCKED = 2'd0,
    ST_ARMED  = 2'd1,
    ST_OPEN   = 2'd2
  } unlockState_t;

  typedef struct packed {
    logic          open;
    logic          dataWr;
    logic          dataRd;
    logic          idxRd;
    logic [DW-1:0] idx;
  } cfgStrobe_t;
endpackage

// File: rtl/cfgport_ctrl.sv
module cfgport_ctrl
  import cfgport_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          addrSel,
  input  logic          wrEn,
  input  logic          rdEn,
  input  logic [DW-1:0] wrData,
  output cfgStrobe_t    strb
);
  unlockState_t state;
  logic [DW-1:0] idxReg;
  logic idxWr;
  logic isEnter;

  assign idxWr   = wrEn && !addrSel;
  assign isEnter = (wrData == ENTER_KEY);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_LOCKED;
      idxReg <= '0;
    end else if (idxWr) begin
      unique case (state)
        ST_LOCKED: state <= isEnter ? ST_ARMED : ST_LOCKED;
        ST_ARMED:  state <= isEnter ? ST_OPEN : ST_LOCKED;
        ST_OPEN: begin
          if (wrData == EXIT_KEY) state <= ST_LOCKED;
          else idxReg <= wrData;
        end
        default: state <= ST_LOCKED;
      endcase
    end
  end

  always_comb begin
    strb.open   = (state == ST_OPEN);
    strb.dataWr = wrEn && addrSel && (state == ST_OPEN);
    strb.dataRd = rdEn && addrSel;
    strb.idxRd  = rdEn && !addrSel;
    strb.idx    = idxReg;
  end
endmodule

// File: rtl/cfgport_regs.sv
module cfgport_regs
  import cfgport_pkg::*;
#(
  parameter int              NUM_LD  = 12,
  parameter int              WDT_LDN = 8,
  parameter logic [DW-1:0]   CHIP_ID = 8'h5C
) (
  input  logic          clk,
  input  logic          rstN,
  input  cfgStrobe_t    strb,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] rdData,
  output logic [DW-1:0] wdtCtrl,
  output logic [DW-1:0] wdtTimeout,
  output logic [DW-1:0] wdtCsr,
  output logic          wdtActive
);
  localparam int LD_W = (NUM_LD > 1) ? $clog2(NUM_LD) : 1;
  localparam logic [DW-1:0] WDT_END = REG_WDT_BASE + DW'(WDT_REGS);

  logic [DW-1:0] devSel;
  logic [NUM_LD-1:0] actBits;
  logic [DW-1:0] wdtRegs [WDT_REGS];
  logic devValid;
  logic [LD_W-1:0] devIdx;
  logic isWdtBank;
  logic inWdtRange;
  logic [1:0] wdtSel;
  logic [DW-1:0] regVal;

  assign devValid   = int'(devSel) < NUM_LD;
  assign devIdx     = devSel[LD_W-1:0];
  assign isWdtBank  = int'(devSel) == WDT_LDN;
  assign inWdtRange = (strb.idx >= REG_WDT_BASE) && (strb.idx < WDT_END);
  assign wdtSel     = 2'(strb.idx - REG_WDT_BASE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      devSel <= '0;
    end else if (strb.dataWr && strb.idx == REG_DEVSEL) begin
      devSel <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actBits <= '0;
    end else if (strb.dataWr && strb.idx == REG_ACTIVE && devValid) begin
      for (int i = 0; i < NUM_LD; i++)
        if (devIdx == LD_W'(i)) actBits[i] <= wrData[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < WDT_REGS; i++) wdtRegs[i] <= '0;
    end else if (strb.dataWr && isWdtBank && inWdtRange) begin
      for (int i = 0; i < WDT_REGS; i++)
        if (wdtSel == 2'(i)) wdtRegs[i] <= wrData;
    end
  end

  always_comb begin
    regVal = '0;
    if (strb.idx == REG_DEVSEL) regVal = devSel;
    else if (strb.idx == REG_IDENT) regVal = CHIP_ID;
    else if (strb.idx == REG_ACTIVE) begin
      if (devValid) regVal = {{(DW-1){1'b0}}, actBits[devIdx]};
    end else if (inWdtRange && isWdtBank) begin
      for (int i = 0; i < WDT_REGS; i++)
        if (wdtSel == 2'(i)) regVal = wdtRegs[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (strb.dataRd) begin
      rdData <= strb.open ? regVal : LOCKED_READ;
    end else if (strb.idxRd) begin
      rdData <= strb.open ? strb.idx : LOCKED_READ;
    end
  end

  assign wdtCtrl    = wdtRegs[0];
  assign wdtTimeout = wdtRegs[1];
  assign wdtCsr     = wdtRegs[2];
  assign wdtActive  = actBits[WDT_LDN];
endmodule

// File: rtl/cfgport_top.sv
module cfgport_top
  import cfgport_pkg::*;
#(
  parameter int            NUM_LD  = 12,
  parameter int            WDT_LDN = 8,
  parameter logic [7:0]    CHIP_ID = 8'h5C
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       addrSel,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  output logic [7:0] wdtCtrl,
  output logic [7:0] wdtTimeout,
  output logic [7:0] wdtCsr,
  output logic       wdtActive
);
  cfgStrobe_t strb;

  cfgport_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .addrSel(addrSel), .wrEn(wrEn),
    .rdEn(rdEn), .wrData(wrData), .strb(strb)
  );

  cfgport_regs #(.NUM_LD(NUM_LD), .WDT_LDN(WDT_LDN), .CHIP_ID(CHIP_ID)) u_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .rdData(rdData),
    .wdtCtrl(wdtCtrl), .wdtTimeout(wdtTimeout), .wdtCsr(wdtCsr),
    .wdtActive(wdtActive)
  );
endmodule

// File: rtl/cfgport_checker.sv
module cfgport_checker #(
  parameter logic [7:0] CHIP_ID = 8'h5C
) (
  input logic       clk,
  input logic       rstN,
  input logic       addrSel,
  input logic       wrEn,
  input logic       rdEn,
  input logic [7:0] wrData,
  input logic [7:0] rdData,
  input logic [7:0] wdtCtrl,
  input logic [7:0] wdtTimeout,
  input logic [7:0] wdtCsr,
  input logic       wdtActive,
  input logic       isOpen,
  input logic [7:0] curIdx
);
  // R2: the port only opens right after an index write of the entry key
  a_r2_open_after_key: assert property (@(posedge clk) disable iff (!rstN)
    $rose(isOpen) |-> $past(wrEn && !addrSel && wrData == 8'h87));

  // R3: a non-key index write while locked keeps the port locked
  a_r3_wrong_byte_stays_locked: assert property (@(posedge clk) disable iff (!rstN)
    (!isOpen && wrEn && !addrSel && wrData != 8'h87) |=> !isOpen);

  // R4: nothing toward the watchdog moves while locked
  a_r4_locked_outputs_stable: assert property (@(posedge clk) disable iff (!rstN)
    !isOpen |=> $stable({wdtCtrl, wdtTimeout, wdtCsr, wdtActive}));

  // R5: the exit key locks the open port
  a_r5_exit_locks: assert property (@(posedge clk) disable iff (!rstN)
    (isOpen && wrEn && !addrSel && wrData == 8'hAA) |=> !isOpen);

  // R6: read data holds without a read strobe; locked reads give 0xFF
  a_r6_rd_hold: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData));
  a_r6_locked_read: assert property (@(posedge clk) disable iff (!rstN)
    (!isOpen && rdEn) |=> rdData == 8'hFF);

  // R7: identification register read
  a_r7_ident_read: assert property (@(posedge clk) disable iff (!rstN)
    (isOpen && rdEn && addrSel && curIdx == 8'h20) |=> rdData == CHIP_ID);
endmodule

bind cfgport_top cfgport_checker #(.CHIP_ID(CHIP_ID)) u_chk (
  .clk(clk), .rstN(rstN), .addrSel(addrSel), .wrEn(wrEn), .rdEn(rdEn),
  .wrData(wrData), .rdData(rdData), .wdtCtrl(wdtCtrl),
  .wdtTimeout(wdtTimeout), .wdtCsr(wdtCsr), .wdtActive(wdtActive),
  .isOpen(strb.open), .curIdx(strb.idx)
);

// File: tb/tb_cfgport_top.sv
module tb_cfgport_top;
  localparam int NLD = 12;
  localparam int WLD = 8;
  localparam logic [7:0] ID = 8'h5C;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic addrSel = 1'b0, wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData, wdtCtrl, wdtTimeout, wdtCsr;
  logic wdtActive;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  bit started = 0;
  string curReq = "R1";

  always #2 clk = ~clk;

  cfgport_top #(.NUM_LD(NLD), .WDT_LDN(WLD), .CHIP_ID(ID)) dut (
    .clk(clk), .rstN(rstN), .addrSel(addrSel), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .wdtCtrl(wdtCtrl),
    .wdtTimeout(wdtTimeout), .wdtCsr(wdtCsr), .wdtActive(wdtActive)
  );

  // behavioural reference model: 0 locked, 1 one key seen, 2 open
  int mState;
  int mIdx, mLdn, mRd;
  int mWdt [3];
  bit mAct [NLD];

  function automatic int modelRead();
    if (mIdx == 'h07) return mLdn;
    if (mIdx == 'h20) return int'(ID);
    if (mIdx == 'h30) return (mLdn < NLD) ? int'(mAct[mLdn]) : 0;
    if (mIdx >= 'hF5 && mIdx <= 'hF7 && mLdn == WLD) return mWdt[mIdx - 'hF5];
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; mIdx = 0; mLdn = 0; mRd = 0;
      foreach (mWdt[i]) mWdt[i] = 0;
      foreach (mAct[i]) mAct[i] = 0;
    end else begin
      if (rdEn) begin
        if (mState != 2) mRd = 'hFF;
        else if (addrSel) mRd = modelRead();
        else mRd = mIdx;
      end
      if (wrEn && !addrSel) begin
        if (mState == 0) mState = (wrData == 8'h87) ? 1 : 0;
        else if (mState == 1) mState = (wrData == 8'h87) ? 2 : 0;
        else if (wrData == 8'hAA) mState = 0;
        else mIdx = int'(wrData);
      end else if (wrEn && addrSel && mState == 2) begin
        if (mIdx == 'h07) mLdn = int'(wrData);
        else if (mIdx == 'h30 && mLdn < NLD) mAct[mLdn] = wrData[0];
        else if (mIdx >= 'hF5 && mIdx <= 'hF7 && mLdn == WLD) mWdt[mIdx - 'hF5] = int'(wrData);
      end
    end
  end

  task automatic cmp(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && rstN) begin
      cmp(curReq, "model rdData", int'(rdData), mRd);
      cmp(curReq, "model wdtCtrl", int'(wdtCtrl), mWdt[0]);
      cmp(curReq, "model wdtTimeout", int'(wdtTimeout), mWdt[1]);
      cmp(curReq, "model wdtCsr", int'(wdtCsr), mWdt[2]);
      cmp(curReq, "model wdtActive", int'(wdtActive), int'(mAct[WLD]));
    end
  end

  task automatic op(input bit a, input bit w, input bit r, input logic [7:0] d);
    addrSel = a; wrEn = w; rdEn = r; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
  endtask

  task automatic idxWr(input logic [7:0] d); op(1'b0, 1'b1, 1'b0, d); endtask
  task automatic datWr(input logic [7:0] d); op(1'b1, 1'b1, 1'b0, d); endtask
  task automatic datRd(); op(1'b1, 1'b0, 1'b1, 8'h00); endtask
  task automatic idxRd(); op(1'b0, 1'b0, 1'b1, 8'h00); endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    started = 1;
    @(negedge clk);
    // R1 reset state
    cmp("R1", "rdData after reset", int'(rdData), 'h00);
    cmp("R1", "wdtTimeout after reset", int'(wdtTimeout), 'h00);
    cmp("R1", "wdtActive after reset", int'(wdtActive), 0);

    curReq = "R2";
    datRd(); cmp("R2", "locked data read", int'(rdData), 'hFF);
    curReq = "R6";
    idxRd(); cmp("R6", "locked index read", int'(rdData), 'hFF);

    curReq = "R4";
    idxWr(8'hF6); datWr(8'h33);
    cmp("R4", "locked write wdtTimeout", int'(wdtTimeout), 'h00);

    curReq = "R3";
    idxWr(8'h87); idxWr(8'h55); idxWr(8'h87); datRd();
    cmp("R3", "read after broken key", int'(rdData), 'hFF);
    curReq = "R2";
    idxWr(8'h87); idxRd();
    cmp("R2", "index read after opening", int'(rdData), 'h00);

    curReq = "R7";
    idxWr(8'h20); datRd(); cmp("R7", "ident read", int'(rdData), 'h5C);
    datWr(8'h11); datRd(); cmp("R7", "ident after write", int'(rdData), 'h5C);

    curReq = "R8";
    idxWr(8'h07); datWr(8'h08); datRd(); cmp("R8", "device select", int'(rdData), 'h08);

    curReq = "R4";
    idxWr(8'hF6); datRd(); cmp("R4", "timeout after locked write", int'(rdData), 'h00);

    curReq = "R9";
    idxWr(8'h30); datWr(8'hFF); datRd(); cmp("R9", "active reg", int'(rdData), 'h01);
    cmp("R9", "wdtActive", int'(wdtActive), 1);

    curReq = "R10";
    idxWr(8'hF6); datWr(8'h3C); datRd(); cmp("R10", "timeout read", int'(rdData), 'h3C);
    cmp("R10", "wdtTimeout", int'(wdtTimeout), 'h3C);
    idxWr(8'hF5); datWr(8'h0A); cmp("R10", "wdtCtrl", int'(wdtCtrl), 'h0A);
    idxWr(8'hF7); datWr(8'hC5); cmp("R10", "wdtCsr", int'(wdtCsr), 'hC5);

    curReq = "R11";
    idxWr(8'h07); datWr(8'h03); idxWr(8'hF6); datRd();
    cmp("R11", "other bank read", int'(rdData), 'h00);
    datWr(8'h77); cmp("R11", "wdtTimeout after other-bank write", int'(wdtTimeout), 'h3C);
    curReq = "R9";
    idxWr(8'h30); datRd(); cmp("R9", "device 3 inactive", int'(rdData), 'h00);
    idxWr(8'h07); datWr(8'h20); idxWr(8'h30); datWr(8'h01); datRd();
    cmp("R9", "out-of-range device", int'(rdData), 'h00);
    idxWr(8'h07); datWr(8'h08); idxWr(8'h30); datRd();
    cmp("R9", "watchdog device still active", int'(rdData), 'h01);

    curReq = "R12";
    idxWr(8'h55); datWr(8'h12); datRd(); cmp("R12", "unimplemented read", int'(rdData), 'h00);

    curReq = "R6";
    op(1'b1, 1'b0, 1'b0, 8'h00); op(1'b0, 1'b0, 1'b0, 8'h00);
    cmp("R6", "hold without read", int'(rdData), 'h00);

    curReq = "R5";
    idxWr(8'hF7); idxWr(8'hAA); datRd(); cmp("R5", "read after exit", int'(rdData), 'hFF);
    datWr(8'h00); cmp("R5", "wdtCsr after locked write", int'(wdtCsr), 'hC5);
    idxWr(8'h87); idxWr(8'h87); datRd();
    cmp("R5", "index kept across lock", int'(rdData), 'hC5);

    curReq = "R3";
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] pick;
      int sel;
      sel = int'($urandom_range(0, 11));
      case (sel)
        0, 1: pick = 8'h87;
        2: pick = 8'hAA;
        3: pick = 8'h07;
        4: pick = 8'h30;
        5: pick = 8'hF5 + 8'($urandom_range(0, 2));
        6: pick = 8'h20;
        7: pick = 8'($urandom_range(0, 15));
        default: pick = 8'($urandom);
      endcase
      op(1'($urandom), 1'($urandom), 1'($urandom), pick);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule